// File: doc/BRIEF.md
# Nine-bit multidrop serial receiver

This block receives asynchronous serial frames of eleven bit periods on a shared multidrop line. A frame is one low start bit, eight data bits sent least significant bit first, a ninth bit that marks the frame as an address (1) or as data (0), and one high stop bit. An external strobe, `os_tick`, pulses once per sixteenth of a bit period. The block places each bit on that grid and votes on three samples near the middle of the bit. When a frame completes, the byte goes to a holding register, the ninth bit goes to its own register, and a receive-complete flag is set.

A host-writable filter bit lets a node that has not been addressed ignore data traffic. While the filter bit is set, only frames whose ninth bit is 1 set the flag. An optional comparator checks each stored address byte against the node's own address. On a match it clears the filter bit, so that the data frames which follow are accepted. If a frame ends while the flag is still pending, that frame is dropped and an overrun flag is set.

The receiver state machine has four states:

- **IDLE**: waits for a low sample on a tick.
- **START**: checks the start bit. It returns to IDLE on a false start, or moves to DATA at the end of the bit period.
- **DATA**: collects nine bits, then moves to STOP.
- **STOP**: samples the stop bit, reports the end of the frame, and returns to IDLE.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is a start bit of 0, then eight data bits sent least significant bit first, then the ninth bit, then a stop bit of 1. When a frame completes with a high stop bit and is accepted, `rx_data` takes the eight data bits and `rx_bit9` takes the ninth bit.
- R2: While `filt_mode` is 0, every frame that completes sets `rx_done`, whatever its ninth bit is.
- R3: While `filt_mode` is 1, a frame whose ninth bit is 1 sets `rx_done`.
- R4: While `filt_mode` is 1, a frame whose ninth bit is 0 leaves `rx_done`, `rx_data` and `rx_bit9` unchanged.
- R5: The filter bit is cleared in the same cycle that `rx_done` rises when all of these hold: `match_en` is 1, `filt_mode` is 1, and a stored address frame carries a byte equal to `node_addr`.
- R6: An address frame whose byte differs from `node_addr` leaves `filt_mode` unchanged. So does any frame received while `match_en` is 0.
- R7: Each bit is split into 16 tick positions, numbered 0 to 15, where position 0 of the start bit is the first tick on which the line is seen low. Each bit's value is the majority of the samples at positions 7, 8 and 9. If the majority for the start bit is 1, the receiver returns to idle and no frame is reported.
- R8: A frame whose stop-bit majority is 0 is discarded: no flag is set and no register changes.
- R9: If `rx_done` is still 1 when an accepted frame ends, that frame is discarded, `rx_ovr` is set, and `rx_data` and `rx_bit9` keep the earlier frame.
- R10: `rx_done` and `rx_ovr` stay set until a one-cycle pulse on `clr_flags` clears both.
- R11: A pulse on `filt_wr` loads `filt_wdata` into `filt_mode`. After reset, `rx_done`, `rx_ovr` and `filt_mode` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| node_addr | input | 8 | This node's network address |
| match_en | input | 1 | Enables the comparator that releases the filter bit |
| filt_wr | input | 1 | Host write strobe for the filter bit |
| filt_wdata | input | 1 | Value written to the filter bit |
| clr_flags | input | 1 | One-cycle clear of the receive-complete and overrun flags |
| rx_data | output | 8 | Holding register for the received byte |
| rx_bit9 | output | 1 | Ninth bit of the stored frame |
| rx_done | output | 1 | Receive-complete flag |
| rx_ovr | output | 1 | Overrun flag |
| filt_mode | output | 1 | Filter bit: 1 means only address frames are accepted |

## Verification
Most internal faults in this block show up as soon as the next frame ends.

- **Sample counter or bit index off by one:** the stored byte comes out shifted by one bit, or the frame is cut short so that a later start edge is misread.
- **Acceptance logic wrong:** a data frame raises `rx_done` while the filter bit is set, or an accepted frame never raises it. This is visible one clock after the stop-bit decision.
- **Comparator wrong:** `filt_mode` stays set, or falls, in the same cycle as the address frame is stored. The error then repeats on every data frame that follows.
- **Overrun logic wrong:** the pending byte is replaced by the second frame instead of being kept.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    // majority of three line samples, given the count of ones seen
    function automatic logic vote_high(input logic [1:0] ones);
        return ones >= 2'd2;
    endfunction

endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/mprx_frame_fsm.sv
module mprx_frame_fsm
    import mprx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int NB  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          line,
    output logic          frame_end,
    output logic          stop_ok,
    output logic [NB-1:0] frame_bits
);

    localparam int CW  = $clog2(OSR);
    localparam int IW  = $clog2(NB + 1);
    localparam int MID = OSR / 2;
    localparam logic [CW-1:0] POS_FIRST = CW'(MID - 1);
    localparam logic [CW-1:0] POS_DEC   = CW'(MID + 1);
    localparam logic [CW-1:0] POS_LAST  = CW'(OSR - 1);
    localparam logic [IW-1:0] IDX_FULL  = IW'(NB);

    rx_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [1:0]    ones_q, ones_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [NB-1:0] sh_q, sh_d;

    logic          in_win;
    logic          at_dec;
    logic          at_end;
    logic [1:0]    ones_now;
    logic          maj;

    assign in_win   = (cnt_q >= POS_FIRST) && (cnt_q <= POS_DEC);
    assign at_dec   = (cnt_q == POS_DEC);
    assign at_end   = (cnt_q == POS_LAST);
    assign ones_now = ones_q + {1'b0, line};
    assign maj      = vote_high(ones_now);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            ones_q  <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ones_q  <= ones_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ones_d  = ones_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d  = '0;
                    ones_d = '0;
                    if (!line) begin
                        state_d = ST_START;
                        cnt_d   = CW'(1);
                    end
                end
                ST_START, ST_DATA, ST_STOP: begin
                    cnt_d = at_end ? '0 : cnt_q + CW'(1);
                    if (in_win) begin
                        ones_d = ones_now;
                    end
                    if (at_end) begin
                        ones_d = '0;
                    end
                    if (state_q == ST_START) begin
                        if (at_dec && maj) begin
                            state_d = ST_IDLE;   // false start
                            cnt_d   = '0;
                            ones_d  = '0;
                        end else if (at_end) begin
                            state_d = ST_DATA;
                            idx_d   = '0;
                        end
                    end else if (state_q == ST_DATA) begin
                        if (at_dec) begin
                            sh_d  = {maj, sh_q[NB-1:1]};
                            idx_d = idx_q + IW'(1);
                        end
                        if (at_end && idx_q == IDX_FULL) begin
                            state_d = ST_STOP;
                        end
                    end else begin
                        if (at_dec) begin
                            state_d = ST_IDLE;
                            cnt_d   = '0;
                            ones_d  = '0;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        frame_end  = tick && (state_q == ST_STOP) && at_dec;
        stop_ok    = maj;
        frame_bits = sh_q;
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (idx_q <= IDX_FULL)) else $error("index overrun"); // R1

    AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (state_q == ST_IDLE)) else $error("stop not followed by idle"); // R7

endmodule

// File: rtl/mprx_accept.sv
module mprx_accept #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_end,
    input  logic          stop_ok,
    input  logic [DW:0]   frame_bits,
    input  logic [DW-1:0] node_addr,
    input  logic          match_en,
    input  logic          filt_wr,
    input  logic          filt_wdata,
    input  logic          clr_flags,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_done,
    output logic          rx_ovr,
    output logic          filt_mode
);

    logic          good_frame;
    logic          accept;
    logic          store;
    logic          hit;
    logic [DW-1:0] byte_in;
    logic          b9_in;

    assign byte_in    = frame_bits[DW-1:0];
    assign b9_in      = frame_bits[DW];
    assign good_frame = frame_end && stop_ok;
    assign accept     = good_frame && (!filt_mode || b9_in);
    assign store      = accept && (!rx_done || clr_flags);
    assign hit        = store && filt_mode && b9_in && match_en && (byte_in == node_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data   <= '0;
            rx_bit9   <= 1'b0;
            rx_done   <= 1'b0;
            rx_ovr    <= 1'b0;
            filt_mode <= 1'b0;
        end else begin
            if (clr_flags) begin
                rx_done <= 1'b0;
                rx_ovr  <= 1'b0;
            end
            if (store) begin
                rx_data <= byte_in;
                rx_bit9 <= b9_in;
                rx_done <= 1'b1;
            end else if (accept) begin
                rx_ovr  <= 1'b1;
            end
            if (filt_wr) begin
                filt_mode <= filt_wdata;
            end else if (hit) begin
                filt_mode <= 1'b0;
            end
        end
    end

    AST_FILTER_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_done) && $past(filt_mode)) |-> rx_bit9) else $error("data frame passed filter"); // R4

    AST_RELEASE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(filt_mode) && !$past(filt_wr)) |-> (rx_done && rx_bit9 && rx_data == $past(node_addr)))
        else $error("filter released without match"); // R5

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> ($stable(rx_data) && $stable(rx_bit9))) else $error("overrun replaced data"); // R9

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !clr_flags) |=> rx_done) else $error("flag dropped without clear"); // R10

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          os_tick,
    input  logic [DW-1:0] node_addr,
    input  logic          match_en,
    input  logic          filt_wr,
    input  logic          filt_wdata,
    input  logic          clr_flags,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_done,
    output logic          rx_ovr,
    output logic          filt_mode
);

    localparam int NB = DW + 1;

    logic          line_s;
    logic          frame_end;
    logic          stop_ok;
    logic [NB-1:0] frame_bits;

    mprx_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rxd),
        .d_out (line_s)
    );

    mprx_frame_fsm #(.OSR(OSR), .NB(NB)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .line       (line_s),
        .frame_end  (frame_end),
        .stop_ok    (stop_ok),
        .frame_bits (frame_bits)
    );

    mprx_accept #(.DW(DW)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .stop_ok    (stop_ok),
        .frame_bits (frame_bits),
        .node_addr  (node_addr),
        .match_en   (match_en),
        .filt_wr    (filt_wr),
        .filt_wdata (filt_wdata),
        .clr_flags  (clr_flags),
        .rx_data    (rx_data),
        .rx_bit9    (rx_bit9),
        .rx_done    (rx_done),
        .rx_ovr     (rx_ovr),
        .filt_mode  (filt_mode)
    );

endmodule

// File: tb/mp_uart_rx_bench.sv
`timescale 1ns/1ps
module mp_uart_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic [7:0] node_addr = 8'h00;
    logic       match_en = 1'b0;
    logic       filt_wr = 1'b0;
    logic       filt_wdata = 1'b0;
    logic       clr_drv = 1'b0;
    logic       clr_mon = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_done;
    logic       rx_ovr;
    logic       filt_mode;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];
    logic auto_clr = 1'b1;
    logic [1:0] div = '0;

    always #10 clk = ~clk;

    mp_uart_rx u_mp_uart_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .node_addr(node_addr), .match_en(match_en),
        .filt_wr(filt_wr), .filt_wdata(filt_wdata),
        .clr_flags(clr_drv | clr_mon),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_done(rx_done),
        .rx_ovr(rx_ovr), .filt_mode(filt_mode)
    );

    always @(posedge clk) begin
        div     <= div + 2'd1;
        os_tick <= (div == 2'd3);
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (!os_tick) @(posedge clk);
        end
    endtask

    task automatic drive_bit(input logic v);
        @(negedge clk);
        rxd = v;
        wait_ticks(16);
    endtask

    task automatic send(input logic [7:0] d, input logic b9, input logic stopb);
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(d[i]);
        drive_bit(b9);
        drive_bit(stopb);
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(4);
    endtask

    task automatic write_filt(input logic v);
        @(negedge clk);
        filt_wr = 1'b1;
        filt_wdata = v;
        @(negedge clk);
        filt_wr = 1'b0;
    endtask

    // monitor: pops the scoreboard on each rising receive flag
    initial begin
        logic prev;
        logic [8:0] e;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            clr_mon = 1'b0;
            if (rst_n && rx_done && !prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected frame flag", {rx_bit9, rx_data}, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({rx_bit9, rx_data} == e, "R1 received frame", {rx_bit9, rx_data}, e);
                end
                if (auto_clr) clr_mon = 1'b1;
            end
            prev = rx_done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rx_done && !rx_ovr && !filt_mode && rx_data == 8'h00, "R11 reset state",
              {rx_done, rx_ovr, filt_mode, rx_data}, 0);
        wait_ticks(20);

        // R2: no filter, both kinds of frame
        exp_q.push_back({1'b0, 8'hA5}); send(8'hA5, 1'b0, 1'b1);
        exp_q.push_back({1'b1, 8'h3C}); send(8'h3C, 1'b1, 1'b1);
        check(exp_q.size() == 0, "R2 frames without filter", exp_q.size(), 0);

        // R11 host write of filter bit
        write_filt(1'b1);
        check(filt_mode == 1'b1, "R11 filter write", filt_mode, 1);
        node_addr = 8'h5A;
        match_en = 1'b1;

        // R4 data frame ignored
        send(8'h77, 1'b0, 1'b1);
        check(!rx_done && rx_data == 8'h3C && rx_bit9 == 1'b1, "R4 data ignored",
              {rx_done, rx_bit9, rx_data}, {1'b0, 1'b1, 8'h3C});

        // R3 and R6: mismatched address accepted, filter kept
        exp_q.push_back({1'b1, 8'h33}); send(8'h33, 1'b1, 1'b1);
        check(exp_q.size() == 0, "R3 address frame accepted", exp_q.size(), 0);
        check(filt_mode == 1'b1, "R6 mismatch keeps filter", filt_mode, 1);

        // R5 matched address releases filter
        exp_q.push_back({1'b1, 8'h5A}); send(8'h5A, 1'b1, 1'b1);
        check(filt_mode == 1'b0, "R5 match clears filter", filt_mode, 0);
        exp_q.push_back({1'b0, 8'h11}); send(8'h11, 1'b0, 1'b1);
        check(exp_q.size() == 0, "R5 data after release", exp_q.size(), 0);

        // R6 comparator disabled
        write_filt(1'b1);
        match_en = 1'b0;
        exp_q.push_back({1'b1, 8'h5A}); send(8'h5A, 1'b1, 1'b1);
        check(filt_mode == 1'b1, "R6 comparator off keeps filter", filt_mode, 1);
        write_filt(1'b0);

        // R7 false start
        @(negedge clk); rxd = 1'b0;
        wait_ticks(4);
        @(negedge clk); rxd = 1'b1;
        wait_ticks(40);
        check(!rx_done && rx_data == 8'h5A, "R7 false start ignored", {rx_done, rx_data}, 8'h5A);
        exp_q.push_back({1'b0, 8'hC3}); send(8'hC3, 1'b0, 1'b1);
        check(exp_q.size() == 0, "R7 frame after false start", exp_q.size(), 0);

        // R8 bad stop bit
        send(8'h99, 1'b1, 1'b0);
        wait_ticks(40);
        check(!rx_done && rx_data == 8'hC3 && rx_bit9 == 1'b0, "R8 framing error dropped",
              {rx_done, rx_bit9, rx_data}, {1'b0, 1'b0, 8'hC3});

        // R9 overrun
        auto_clr = 1'b0;
        exp_q.push_back({1'b0, 8'h12}); send(8'h12, 1'b0, 1'b1);
        send(8'h34, 1'b1, 1'b1);
        check(rx_ovr && rx_done && rx_data == 8'h12 && !rx_bit9, "R9 overrun keeps data",
              {rx_ovr, rx_done, rx_bit9, rx_data}, {1'b1, 1'b1, 1'b0, 8'h12});

        // R10 clear
        @(negedge clk); clr_drv = 1'b1;
        @(negedge clk); clr_drv = 1'b0;
        check(!rx_done && !rx_ovr, "R10 clear flags", {rx_done, rx_ovr}, 0);
        auto_clr = 1'b1;

        wait_ticks(8);
        check(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule